// File: doc/BRIEF.md
# Interrupt Entry and Context Shadow

This block sits beside a small processor core and handles the hardware side of taking an interrupt. Interrupt requests, such as a timer-counter rollover, are collected into one pending flag. The request is taken only when the core signals that it has finished an instruction. When the request is taken, the block copies four live values into a single bank of shadow registers: the program counter of the next unexecuted instruction, the working register, the status register and the indirect-address register. In the next cycle it tells the core to load the program counter with a fixed vector address.

When the core later pulses its return strobe, the block presents all four saved values for exactly one cycle, together with load strobes. The core then resumes at the interrupted instruction with its context intact. The shadow bank has a single level, so interrupts do not nest. A request that arrives during service waits until after the return. Instruction decode and the timer itself are outside this block.

Top module: `irq_ctx_shadow`

## Requirements
- R1: After reset both `pc_load_o` and `ctx_load_o` are low, no request is pending and the block is not servicing.
- R2: An entry happens in a cycle where `ibnd_i` is high, the block is not servicing and a request is pending or present on `irq_req_i`. In the cycle after that, `pc_load_o` is high for one cycle, `pc_val_o` equals the vector (parameter `VEC_ADDR`, default 0) and `ctx_load_o` stays low.
- R3: An entry stores the values of `pc_i`, `w_i`, `status_i` and `fsr_i` from the boundary cycle. Later changes on those inputs do not alter the stored copy.
- R4: A high `reti_i` while servicing ends the service. In the following cycle, and only that cycle, `pc_load_o` and `ctx_load_o` are both high, and `pc_val_o`, `w_o`, `status_o`, `fsr_o` carry the four stored values.
- R5: A request is never taken without `ibnd_i`. It stays pending until the next boundary strobe. A boundary strobe with nothing pending causes no strobe.
- R6: No entry happens while servicing. A request that arrives during service is held and is taken at the first boundary strobe from the cycle after `reti_i` onward.
- R7: Several request pulses before an entry cause one entry only. This includes pulses on different sources and a pulse in the entry cycle itself.
- R8: A high `reti_i` while not servicing is ignored: no strobe follows, and the next real service saves and restores normally.
- R9: Every bit of `irq_req_i` is an independent source of equal weight. Bit 0 is intended for the timer-counter rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req_i | input | N_SRC | Request pulses, one bit per source |
| ibnd_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | PC_W | Address of the next unexecuted instruction |
| w_i | input | DW | Live working register |
| status_i | input | DW | Live status register |
| fsr_i | input | DW | Live indirect-address register |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_val_o | output | PC_W | Value for the program counter, valid with `pc_load_o` |
| ctx_load_o | output | 1 | Restore strobe for the three data registers |
| w_o | output | DW | Restored working register, valid with `ctx_load_o` |
| status_o | output | DW | Restored status register, valid with `ctx_load_o` |
| fsr_o | output | DW | Restored indirect-address register, valid with `ctx_load_o` |

## Verification
A lost or stuck pending flag shows one cycle after the next boundary strobe, as a vector load that is missing or unexpected. A wrong servicing flag shows as a nested entry, or as a restore strobe after a stray return. A corrupted shadow slot stays hidden until the return, but then appears in the one restore cycle as a wrong value. The bench therefore always changes the live inputs between entry and return. It compares every strobe against the expected item, in order.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  // Event decided in one cycle and turned into strobes the next cycle.
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_ENTER  = 2'd1,
    EV_RETURN = 2'd2
  } ctx_ev_e;

  // Shadowed data slots besides the program counter: 0 = W, 1 = status, 2 = FSR.
  localparam int NUM_SLOT = 3;

endpackage

// File: rtl/irq_pend_ctl.sv
module irq_pend_ctl
  import irq_ctx_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             ibnd_i,
  input  logic             reti_i,
  output ctx_ev_e          ev_o,
  output logic             active_o
);

  logic pend_q, pend_d, pend_en;
  logic act_q, act_d, act_en;
  logic any_req, take, leave;

  always_comb begin
    any_req = |req_i;
    take    = ibnd_i & ~act_q & (pend_q | any_req);
    leave   = reti_i & act_q;
    // A request in the entry cycle merges into the entry being taken.
    pend_d  = take ? 1'b0 : (pend_q | any_req);
    pend_en = take | any_req;
    act_d   = take;
    act_en  = take | leave;
    if (take)       ev_o = EV_ENTER;
    else if (leave) ev_o = EV_RETURN;
    else            ev_o = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank #(
  parameter int PC_W = 11,
  parameter int DW   = 8,
  parameter int NUM  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_i,
  input  logic [PC_W-1:0]         pc_i,
  input  logic [NUM-1:0][DW-1:0]  dat_i,
  output logic [PC_W-1:0]         sh_pc_o,
  output logic [NUM-1:0][DW-1:0]  sh_dat_o
);

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb pc_d = cap_i ? pc_i : pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (cap_i) pc_q <= pc_d;
  end

  assign sh_pc_o = pc_q;

  for (genvar g = 0; g < NUM; g++) begin : g_slot
    logic [DW-1:0] slot_q, slot_d;

    always_comb slot_d = cap_i ? dat_i[g] : slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else if (cap_i) slot_q <= slot_d;
    end

    assign sh_dat_o[g] = slot_q;
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_ctx_pkg::*;
#(
  parameter int PC_W     = 11,
  parameter int DW       = 8,
  parameter int NUM      = 3,
  parameter int VEC_ADDR = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctx_ev_e                 ev_i,
  input  logic [PC_W-1:0]         sh_pc_i,
  input  logic [NUM-1:0][DW-1:0]  sh_dat_i,
  output logic                    pc_load_o,
  output logic                    ctx_load_o,
  output logic [PC_W-1:0]         pc_val_o,
  output logic [NUM-1:0][DW-1:0]  dat_o
);

  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  logic                   pcl_d, ctl_d, pcv_en, dat_en;
  logic [PC_W-1:0]        pcv_d;
  logic [NUM-1:0][DW-1:0] dat_d;

  always_comb begin
    pcl_d  = (ev_i != EV_NONE);
    ctl_d  = (ev_i == EV_RETURN);
    pcv_en = (ev_i != EV_NONE);
    dat_en = (ev_i == EV_RETURN);
    pcv_d  = (ev_i == EV_ENTER) ? VEC : sh_pc_i;
    dat_d  = sh_dat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load_o  <= 1'b0;
      ctx_load_o <= 1'b0;
      pc_val_o   <= '0;
      dat_o      <= '0;
    end else begin
      pc_load_o  <= pcl_d;
      ctx_load_o <= ctl_d;
      if (pcv_en) pc_val_o <= pcv_d;
      if (dat_en) dat_o    <= dat_d;
    end
  end

endmodule

// File: rtl/irq_ctx_shadow.sv
module irq_ctx_shadow
  import irq_ctx_pkg::*;
#(
  parameter int PC_W     = 11,
  parameter int DW       = 8,
  parameter int N_SRC    = 2,
  parameter int VEC_ADDR = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_req_i,
  input  logic             ibnd_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [DW-1:0]    w_i,
  input  logic [DW-1:0]    status_i,
  input  logic [DW-1:0]    fsr_i,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_val_o,
  output logic             ctx_load_o,
  output logic [DW-1:0]    w_o,
  output logic [DW-1:0]    status_o,
  output logic [DW-1:0]    fsr_o
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe[1];

  ctx_ev_e                     ev;
  logic                        active;
  logic [PC_W-1:0]             sh_pc;
  logic [NUM_SLOT-1:0][DW-1:0] sh_dat, live_dat, out_dat;

  assign live_dat = {fsr_i, status_i, w_i};

  irq_pend_ctl #(.N_SRC(N_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (irq_req_i),
    .ibnd_i   (ibnd_i),
    .reti_i   (reti_i),
    .ev_o     (ev),
    .active_o (active)
  );

  ctx_shadow_bank #(.PC_W(PC_W), .DW(DW), .NUM(NUM_SLOT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_i    (ev == EV_ENTER),
    .pc_i     (pc_i),
    .dat_i    (live_dat),
    .sh_pc_o  (sh_pc),
    .sh_dat_o (sh_dat)
  );

  irq_out_stage #(.PC_W(PC_W), .DW(DW), .NUM(NUM_SLOT), .VEC_ADDR(VEC_ADDR)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_i       (ev),
    .sh_pc_i    (sh_pc),
    .sh_dat_i   (sh_dat),
    .pc_load_o  (pc_load_o),
    .ctx_load_o (ctx_load_o),
    .pc_val_o   (pc_val_o),
    .dat_o      (out_dat)
  );

  assign w_o      = out_dat[0];
  assign status_o = out_dat[1];
  assign fsr_o    = out_dat[2];

endmodule

// File: rtl/irq_ctx_shadow_chk.sv
module irq_ctx_shadow_chk #(
  parameter int PC_W     = 11,
  parameter int DW       = 8,
  parameter int NUM      = 3,
  parameter int VEC_ADDR = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ibnd_i,
  input logic                   reti_i,
  input logic                   active,
  input logic                   pc_load_o,
  input logic                   ctx_load_o,
  input logic [PC_W-1:0]        pc_val_o,
  input logic [PC_W-1:0]        pc_i,
  input logic [PC_W-1:0]        sh_pc,
  input logic [NUM-1:0][DW-1:0] live_dat,
  input logic [NUM-1:0][DW-1:0] sh_dat,
  input logic [NUM-1:0][DW-1:0] out_dat
);

  a_r2_vector_value: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_o && !ctx_load_o) |-> (pc_val_o == PC_W'(VEC_ADDR)));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ((sh_pc == $past(pc_i)) && (sh_dat == $past(live_dat))));

  a_r4_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && active) |=> (pc_load_o && ctx_load_o &&
                            pc_val_o == $past(sh_pc) && out_dat == $past(sh_dat)));

  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load_o |=> !ctx_load_o);

  a_r5_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!ibnd_i && !(reti_i && active)) |=> !pc_load_o);

  a_r6_no_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !reti_i) |=> !pc_load_o);

  a_r8_idle_return: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !ctx_load_o);

endmodule

bind irq_ctx_shadow irq_ctx_shadow_chk #(
  .PC_W(PC_W), .DW(DW), .NUM(irq_ctx_pkg::NUM_SLOT), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ibnd_i     (ibnd_i),
  .reti_i     (reti_i),
  .active     (active),
  .pc_load_o  (pc_load_o),
  .ctx_load_o (ctx_load_o),
  .pc_val_o   (pc_val_o),
  .pc_i       (pc_i),
  .sh_pc      (sh_pc),
  .live_dat   (live_dat),
  .sh_dat     (sh_dat),
  .out_dat    (out_dat)
);

// File: tb/irq_ctx_shadow_tb.sv
`timescale 1ns/1ps
module irq_ctx_shadow_tb;

  localparam int PC_W = 11;
  localparam int DW   = 8;
  localparam int NS   = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic [NS-1:0]   irq_req_i;
  logic            ibnd_i, reti_i;
  logic [PC_W-1:0] pc_i;
  logic [DW-1:0]   w_i, status_i, fsr_i;
  logic            pc_load_o, ctx_load_o;
  logic [PC_W-1:0] pc_val_o;
  logic [DW-1:0]   w_o, status_o, fsr_o;

  irq_ctx_shadow #(.PC_W(PC_W), .DW(DW), .N_SRC(NS), .VEC_ADDR(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .ibnd_i(ibnd_i), .reti_i(reti_i),
    .pc_i(pc_i), .w_i(w_i), .status_i(status_i), .fsr_i(fsr_i),
    .pc_load_o(pc_load_o), .pc_val_o(pc_val_o), .ctx_load_o(ctx_load_o),
    .w_o(w_o), .status_o(status_o), .fsr_o(fsr_o)
  );

  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  string cur_tag = "R1";

  // Scoreboard queues: one entry per expected strobe cycle.
  bit              q_ret[$];
  logic [PC_W-1:0] q_pc[$];
  logic [DW-1:0]   q_w[$], q_st[$], q_fsr[$];
  string           q_tag[$];

  task automatic push(bit ret, logic [PC_W-1:0] pc, logic [DW-1:0] w,
                      logic [DW-1:0] st, logic [DW-1:0] fsr, string tag);
    q_ret.push_back(ret); q_pc.push_back(pc); q_w.push_back(w);
    q_st.push_back(st); q_fsr.push_back(fsr); q_tag.push_back(tag);
  endtask

  task automatic step(logic [NS-1:0] rq, bit ib, bit rt, logic [PC_W-1:0] pc,
                      logic [DW-1:0] w, logic [DW-1:0] st, logic [DW-1:0] fsr);
    irq_req_i = rq; ibnd_i = ib; reti_i = rt;
    pc_i = pc; w_i = w; status_i = st; fsr_i = fsr;
    @(posedge clk); #1;
    irq_req_i = '0; ibnd_i = 1'b0; reti_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0, pc_i, w_i, status_i, fsr_i);
  endtask

  task automatic drain(string tag);
    idle(2);
    total++;
    if (q_ret.size() != 0) begin
      bad++;
      $display("FAIL %s: outstanding expected strobes actual=%0d expected=0", tag, q_ret.size());
      q_ret.delete(); q_pc.delete(); q_w.delete(); q_st.delete(); q_fsr.delete(); q_tag.delete();
    end
  endtask

  // Monitor: compares every strobe cycle with the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done && (pc_load_o || ctx_load_o)) begin
      total++;
      if (q_ret.size() == 0) begin
        bad++;
        $display("FAIL %s: unexpected strobe pc_load=%b ctx_load=%b pc=%h expected no strobe",
                 cur_tag, pc_load_o, ctx_load_o, pc_val_o);
      end else begin
        automatic bit              e_ret = q_ret.pop_front();
        automatic logic [PC_W-1:0] e_pc  = q_pc.pop_front();
        automatic logic [DW-1:0]   e_w   = q_w.pop_front();
        automatic logic [DW-1:0]   e_st  = q_st.pop_front();
        automatic logic [DW-1:0]   e_fsr = q_fsr.pop_front();
        automatic string           e_tag = q_tag.pop_front();
        automatic bit ok = pc_load_o && (ctx_load_o == e_ret) && (pc_val_o == e_pc);
        if (e_ret) ok = ok && (w_o == e_w) && (status_o == e_st) && (fsr_o == e_fsr);
        if (!ok) begin
          bad++;
          $display("FAIL %s: actual pcl=%b ctl=%b pc=%h w=%h st=%h fsr=%h expected pcl=1 ctl=%b pc=%h w=%h st=%h fsr=%h",
                   e_tag, pc_load_o, ctx_load_o, pc_val_o, w_o, status_o, fsr_o,
                   e_ret, e_pc, e_w, e_st, e_fsr);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_req_i = '0; ibnd_i = 1'b0; reti_i = 1'b0;
    pc_i = '0; w_i = '0; status_i = '0; fsr_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    // R1: quiet after reset
    @(negedge clk);
    total++;
    if (pc_load_o !== 1'b0 || ctx_load_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: actual pcl=%b ctl=%b expected pcl=0 ctl=0", pc_load_o, ctx_load_o);
    end
    @(posedge clk); #1;

    // R2 / R9: timer source (bit 0) with boundary in the same cycle
    cur_tag = "R2";
    push(1'b0, 11'h000, 8'h00, 8'h00, 8'h00, "R2 R9 vector entry");
    step(2'b01, 1'b1, 1'b0, 11'h123, 8'hA5, 8'h18, 8'h3C);
    idle(3);
    // R3 / R4: live values changed before return; restore must use stored copy
    cur_tag = "R4";
    push(1'b1, 11'h123, 8'hA5, 8'h18, 8'h3C, "R3 R4 restore");
    step('0, 1'b0, 1'b1, 11'h000, 8'h11, 8'h22, 8'h33);
    drain("R4");

    // R5: request on bit 1 with no boundary stays pending
    cur_tag = "R5";
    step(2'b10, 1'b0, 1'b0, 11'h010, 8'h01, 8'h02, 8'h03);
    idle(5);
    push(1'b0, 11'h000, 8'h00, 8'h00, 8'h00, "R5 R9 deferred entry");
    step('0, 1'b1, 1'b0, 11'h7FF, 8'hFF, 8'h80, 8'h7F);
    // R6: request and boundaries while servicing
    cur_tag = "R6";
    step(2'b01, 1'b0, 1'b0, 11'h100, 8'h44, 8'h55, 8'h66);
    for (int i = 0; i < 3; i++) step('0, 1'b1, 1'b0, 11'h101, 8'h44, 8'h55, 8'h66);
    push(1'b1, 11'h7FF, 8'hFF, 8'h80, 8'h7F, "R6 R4 restore");
    push(1'b0, 11'h000, 8'h00, 8'h00, 8'h00, "R6 held entry after return");
    step('0, 1'b0, 1'b1, 11'h101, 8'h44, 8'h55, 8'h66);
    step('0, 1'b1, 1'b0, 11'h055, 8'h9A, 8'hBC, 8'hDE);
    idle(2);
    push(1'b1, 11'h055, 8'h9A, 8'hBC, 8'hDE, "R6 R3 second restore");
    step('0, 1'b0, 1'b1, 11'h000, 8'h00, 8'h00, 8'h00);
    drain("R6");

    // R5: boundaries with nothing pending
    cur_tag = "R5";
    for (int i = 0; i < 3; i++) step('0, 1'b1, 1'b0, 11'h200, 8'h01, 8'h01, 8'h01);
    // R8: returns while idle
    cur_tag = "R8";
    step('0, 1'b0, 1'b1, 11'h200, 8'h01, 8'h01, 8'h01);
    step('0, 1'b0, 1'b1, 11'h200, 8'h01, 8'h01, 8'h01);
    drain("R8");

    // R7: several pulses merged into one entry, plus a pulse in the entry cycle
    cur_tag = "R7";
    step(2'b01, 1'b0, 1'b0, 11'h300, 8'h00, 8'h00, 8'h00);
    step(2'b10, 1'b0, 1'b0, 11'h300, 8'h00, 8'h00, 8'h00);
    step(2'b11, 1'b0, 1'b0, 11'h300, 8'h00, 8'h00, 8'h00);
    push(1'b0, 11'h000, 8'h00, 8'h00, 8'h00, "R7 single entry");
    step(2'b01, 1'b1, 1'b0, 11'h2AA, 8'h5A, 8'hC3, 8'h0F);
    idle(2);
    push(1'b1, 11'h2AA, 8'h5A, 8'hC3, 8'h0F, "R7 R8 restore after stray return");
    step('0, 1'b0, 1'b1, 11'h000, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 3; i++) step('0, 1'b1, 1'b0, 11'h301, 8'h00, 8'h00, 8'h00);
    drain("R7");

    // R6: return, request and boundary in one cycle; entry at next boundary
    cur_tag = "R6";
    push(1'b0, 11'h000, 8'h00, 8'h00, 8'h00, "R6 entry");
    step(2'b10, 1'b1, 1'b0, 11'h0F0, 8'h12, 8'h34, 8'h56);
    push(1'b1, 11'h0F0, 8'h12, 8'h34, 8'h56, "R6 restore");
    push(1'b0, 11'h000, 8'h00, 8'h00, 8'h00, "R6 entry right after return");
    step(2'b01, 1'b1, 1'b1, 11'h0F1, 8'h00, 8'h00, 8'h00);
    step('0, 1'b1, 1'b0, 11'h0F2, 8'h77, 8'h88, 8'h99);
    idle(1);
    push(1'b1, 11'h0F2, 8'h77, 8'h88, 8'h99, "R6 R4 final restore");
    step('0, 1'b0, 1'b1, 11'h000, 8'h00, 8'h00, 8'h00);
    drain("R6");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule